// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block fronts a byte-wide static RAM that is paired with a shadow array holding nonvolatile data. In normal operation it behaves as a plain SRAM. The host drives chip enable, output enable, write enable, an address and a data byte, and the block samples them on a system clock. Besides this array mode, the block has a transfer mode. In that mode the whole SRAM is copied into the shadow array (save) or loaded back from it (restore), and the SRAM bus is locked out.

A save starts in one of three ways: a power-fail warning, a low level on the shared store/busy pad, or a hidden series of six reads. A restore starts on a power-good indication or on the same read series with a different last address. While a transfer runs, the block pulls the store/busy pad low. The pad therefore both requests a save and reports busy. Each transfer moves one location per clock. A restore first zeroes every SRAM location and then loads the shadow contents. The busy period also has a floor set by a programmable cycle count, so the timing of slow nonvolatile parts can be modelled.

Top module: `nvsram_ctrl`

## Requirements
- R1: With the block idle and `ce_n`=0, `we_n`=1, `oe_n`=0 at a clock edge, `dout_en` is 1 and `dout` holds the byte last written to that address, both valid right after that edge. With `oe_n`=1 at that edge, `dout_en` is 0.
- R2: While `hsb_pull_low` is 1, writes do not change the SRAM and `dout_en` stays 0.
- R3: Reads at SEQ_A0, SEQ_A1, SEQ_A2, SEQ_A3, SEQ_A4 and then STORE_TAIL, taken as consecutive read cycles with the chip enabled, start a save in the cycle after the last read. Cycles with `ce_n`=1 between the reads do not count against the series.
- R4: The same five reads followed by a read at RECALL_TAIL start a restore.
- R5: A write, or a read at an address that does not fit the series, aborts the series. A read that aborts the series but equals SEQ_A0 counts as the first step of a new series.
- R6: A low level on `hsb_pad_n` while idle starts a save. A low level on `hsb_pad_n` while a transfer runs has no effect on it.
- R7: `hsb_pull_low` is 1 for the whole transfer and for no other cycle. A save lasts max(DEPTH+2, STORE_CYC) cycles and a restore lasts max(2*DEPTH+2, RECALL_CYC) cycles, where DEPTH is 2^AW.
- R8: A rising edge on `pwr_fail` starts a save only if a write was accepted since the last save or restore began. Otherwise it is ignored.
- R9: A rising edge on `pwr_good` while idle starts a restore.
- R10: When a restore ends, every SRAM location equals the shadow array. The shadow array is left unchanged, so repeated restores give the same contents.
- R11: When a save ends, the shadow array holds every SRAM location as it was when the save began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| dout | output | DW | Read data, meaningful only while dout_en is 1 |
| dout_en | output | 1 | Output driver enable; 0 means the bus is high impedance |
| hsb_pad_n | input | 1 | Sensed level of the shared store/busy pad |
| hsb_pull_low | output | 1 | Open-drain pull-down on the store/busy pad, 1 while busy |
| pwr_fail | input | 1 | Power-fail warning; a rising edge requests a save |
| pwr_good | input | 1 | Power-good indication; a rising edge requests a restore |

## Verification
Two situations are the hardest to reach from the ports: a host that keeps using the bus and pulls the store/busy pad low while a transfer is already running, and a read series that is broken and then picked up again in mid-stream. The bench starts a save from the pad. On every busy cycle it then alternates writes and reads to one address and pulses the pad again. Afterwards it checks that the address still holds its old value and that the busy period has its normal length. For the read series, it interleaves a write, a stray read, and a repeated first address into otherwise valid series. It confirms that only the series that restarts from a read at the first address triggers a transfer.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    NV_IDLE,
    NV_SAVE,
    NV_CLEAR,
    NV_LOAD,
    NV_FLUSH,
    NV_WAIT
  } nv_state_e;
endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match #(
  parameter int AW = 10,
  parameter logic [AW-1:0] SEQ_A0 = '0,
  parameter logic [AW-1:0] SEQ_A1 = '0,
  parameter logic [AW-1:0] SEQ_A2 = '0,
  parameter logic [AW-1:0] SEQ_A3 = '0,
  parameter logic [AW-1:0] SEQ_A4 = '0,
  parameter logic [AW-1:0] STORE_TAIL = '0,
  parameter logic [AW-1:0] RECALL_TAIL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_evt,
  input  logic          abort,
  input  logic [AW-1:0] addr,
  output logic          sw_store,
  output logic          sw_recall
);
  localparam logic [2:0] LAST_STEP = 3'd5;
  localparam logic [AW-1:0] SEQ_TAB [8] =
    '{SEQ_A0, SEQ_A1, SEQ_A2, SEQ_A3, SEQ_A4, '0, '0, '0};

  logic [2:0] step_q;
  logic       step_hit;

  always_comb begin
    step_hit  = (step_q < LAST_STEP) && (addr == SEQ_TAB[step_q]);
    sw_store  = rd_evt && (step_q == LAST_STEP) && (addr == STORE_TAIL);
    sw_recall = rd_evt && (step_q == LAST_STEP) && (addr == RECALL_TAIL);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      step_q <= '0;
    end else if (rd_evt) begin
      if (step_hit)                     step_q <= step_q + 3'd1;
      else if (sw_store || sw_recall)   step_q <= '0;
      else                              step_q <= (addr == SEQ_A0) ? 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
  import nvs_pkg::*;
#(
  parameter int AW         = 10,
  parameter int STORE_CYC  = 3000,
  parameter int RECALL_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_store,
  input  logic          go_recall,
  output logic          busy,
  output logic [AW-1:0] ptr,
  output logic          save_rd,
  output logic          clr_wr,
  output logic          load_rd
);
  localparam int DEPTH = 1 << AW;
  localparam int CMAX  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int TMAX  = (CMAX > 2 * DEPTH + 4) ? CMAX : 2 * DEPTH + 4;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] ST_END = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] RC_END = TW'(RECALL_CYC - 1);
  localparam logic [AW-1:0] PTR_LAST = '1;

  nv_state_e     state_q;
  logic [TW-1:0] tmr_q;
  logic          is_rc_q;

  assign save_rd = (state_q == NV_SAVE);
  assign clr_wr  = (state_q == NV_CLEAR);
  assign load_rd = (state_q == NV_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NV_IDLE;
      busy    <= 1'b0;
      ptr     <= '0;
      tmr_q   <= '0;
      is_rc_q <= 1'b0;
    end else begin
      if (state_q != NV_IDLE) tmr_q <= tmr_q + 1'b1;
      unique case (state_q)
        NV_IDLE: begin
          ptr   <= '0;
          tmr_q <= '0;
          if (go_store) begin
            state_q <= NV_SAVE;
            is_rc_q <= 1'b0;
            busy    <= 1'b1;
          end else if (go_recall) begin
            state_q <= NV_CLEAR;
            is_rc_q <= 1'b1;
            busy    <= 1'b1;
          end
        end
        NV_SAVE: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state_q <= NV_FLUSH;
        end
        NV_CLEAR: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state_q <= NV_LOAD;
        end
        NV_LOAD: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state_q <= NV_FLUSH;
        end
        NV_FLUSH: state_q <= NV_WAIT;
        NV_WAIT: begin
          if (tmr_q >= (is_rc_q ? RC_END : ST_END)) begin
            state_q <= NV_IDLE;
            busy    <= 1'b0;
          end
        end
        default: state_q <= NV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int AW         = 10,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 3000,
  parameter int RECALL_CYC = 1000,
  parameter logic [AW-1:0] SEQ_A0      = AW'('h0E3),
  parameter logic [AW-1:0] SEQ_A1      = AW'('h31C),
  parameter logic [AW-1:0] SEQ_A2      = AW'('h2A5),
  parameter logic [AW-1:0] SEQ_A3      = AW'('h15A),
  parameter logic [AW-1:0] SEQ_A4      = AW'('h0F0),
  parameter logic [AW-1:0] STORE_TAIL  = AW'('h3C3),
  parameter logic [AW-1:0] RECALL_TAIL = AW'('h13C)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          hsb_pad_n,
  output logic          hsb_pull_low,
  input  logic          pwr_fail,
  input  logic          pwr_good
);
  localparam int DEPTH = 1 << AW;

  logic          busy, save_rd, clr_wr, load_rd;
  logic [AW-1:0] ptr, ptr_d;
  logic          save_v, load_v;
  logic          bus_rd, bus_wr;
  logic          sw_store, sw_recall;
  logic          pf_q, pg_q, pf_rise, pg_rise;
  logic          dirty_q;
  logic          go_store, go_recall;

  logic [DW-1:0] sram_mem [DEPTH];
  logic [DW-1:0] shad_mem [DEPTH];
  logic [DW-1:0] sram_q, shad_q;
  logic [AW-1:0] sram_ra, sram_wa;
  logic [DW-1:0] sram_wd;
  logic          sram_we;

  assign bus_rd  = !busy && !ce_n && we_n;
  assign bus_wr  = !busy && !ce_n && !we_n;
  assign pf_rise = pwr_fail && !pf_q;
  assign pg_rise = pwr_good && !pg_q;

  assign go_store  = !busy && ((pf_rise && dirty_q) || !hsb_pad_n || sw_store);
  assign go_recall = !busy && (pg_rise || sw_recall);

  nvs_seq_match #(
    .AW(AW), .SEQ_A0(SEQ_A0), .SEQ_A1(SEQ_A1), .SEQ_A2(SEQ_A2),
    .SEQ_A3(SEQ_A3), .SEQ_A4(SEQ_A4),
    .STORE_TAIL(STORE_TAIL), .RECALL_TAIL(RECALL_TAIL)
  ) u_match (
    .clk(clk), .rst(rst), .rd_evt(bus_rd), .abort(bus_wr || busy),
    .addr(addr), .sw_store(sw_store), .sw_recall(sw_recall)
  );

  nvs_xfer_seq #(
    .AW(AW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_xfer (
    .clk(clk), .rst(rst), .go_store(go_store), .go_recall(go_recall),
    .busy(busy), .ptr(ptr), .save_rd(save_rd), .clr_wr(clr_wr),
    .load_rd(load_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q    <= 1'b0;
      pg_q    <= 1'b0;
      dirty_q <= 1'b0;
      save_v  <= 1'b0;
      load_v  <= 1'b0;
      ptr_d   <= '0;
      dout_en <= 1'b0;
    end else begin
      pf_q    <= pwr_fail;
      pg_q    <= pwr_good;
      if (go_store || go_recall) dirty_q <= 1'b0;
      else if (bus_wr)           dirty_q <= 1'b1;
      save_v  <= save_rd;
      load_v  <= load_rd;
      ptr_d   <= ptr;
      dout_en <= bus_rd && !oe_n;
    end
  end

  // SRAM port: one read address, one write address, mux by phase
  always_comb begin
    sram_ra = save_rd ? ptr : addr;
    if (load_v) begin
      sram_we = 1'b1;
      sram_wa = ptr_d;
      sram_wd = shad_q;
    end else if (clr_wr) begin
      sram_we = 1'b1;
      sram_wa = ptr;
      sram_wd = '0;
    end else begin
      sram_we = bus_wr;
      sram_wa = addr;
      sram_wd = din;
    end
  end

  always_ff @(posedge clk) begin
    sram_q <= sram_mem[sram_ra];
    if (sram_we) sram_mem[sram_wa] <= sram_wd;
  end

  always_ff @(posedge clk) begin
    shad_q <= shad_mem[ptr];
    if (save_v) shad_mem[ptr_d] <= sram_q;
  end

  assign dout         = sram_q;
  assign hsb_pull_low = busy;
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk #(
  parameter int AW         = 10,
  parameter int STORE_CYC  = 3000,
  parameter int RECALL_CYC = 1000
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic dout_en,
  input logic hsb_pad_n,
  input logic hsb_pull_low,
  input logic pwr_fail,
  input logic pwr_good,
  input logic dirty,
  input logic sw_st,
  input logic sw_rc
);
  localparam int DEPTH  = 1 << AW;
  localparam int MINRUN = DEPTH + 2;
  localparam int MAXA   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAXRUN = (MAXA > 2 * DEPTH + 2) ? MAXA : 2 * DEPTH + 2;

  int   run_q;
  logic pf_q, pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 0;
      pf_q  <= 1'b0;
      pg_q  <= 1'b0;
    end else begin
      run_q <= hsb_pull_low ? run_q + 1 : 0;
      pf_q  <= pwr_fail;
      pg_q  <= pwr_good;
    end
  end

  assert_read_only_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> $past(!ce_n && we_n && !oe_n));

  assert_lockout_R2: assert property (@(posedge clk) disable iff (rst)
    (hsb_pull_low && $past(hsb_pull_low)) |-> !dout_en);

  assert_sw_save_R3: assert property (@(posedge clk) disable iff (rst)
    sw_st |=> hsb_pull_low);

  assert_sw_restore_R4: assert property (@(posedge clk) disable iff (rst)
    sw_rc |=> hsb_pull_low);

  assert_pad_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!hsb_pull_low && !hsb_pad_n) |=> hsb_pull_low);

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    (!hsb_pull_low && run_q != 0) |-> (run_q >= MINRUN && run_q <= MAXRUN));

  assert_clean_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (!hsb_pull_low && pwr_fail && !pf_q && !dirty && hsb_pad_n &&
     !(pwr_good && !pg_q) && !sw_st && !sw_rc) |=> !hsb_pull_low);
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(
  .AW(AW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .hsb_pad_n(hsb_pad_n), .hsb_pull_low(hsb_pull_low),
  .pwr_fail(pwr_fail), .pwr_good(pwr_good), .dirty(dirty_q),
  .sw_st(sw_store), .sw_rc(sw_recall)
);

// File: tb/nvsram_ctrl_bench.sv
module nvsram_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int ST_CYC = 40;
  localparam int RC_CYC = 20;
  localparam int ST_LEN = (N + 2 > ST_CYC) ? N + 2 : ST_CYC;
  localparam int RC_LEN = (2 * N + 2 > RC_CYC) ? 2 * N + 2 : RC_CYC;
  localparam logic [AW-1:0] A0 = 4'd3, A1 = 4'd12, A2 = 4'd5, A3 = 4'd10, A4 = 4'd6;
  localparam logic [AW-1:0] TS = 4'd15, TR = 4'd0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, hsb_pull_low, hsb_pad_n;
  logic ext_low = 1'b0;
  logic pwr_fail = 1'b0, pwr_good = 1'b0;

  logic [DW-1:0] sram_m [N];
  logic [DW-1:0] shad_m [N];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  assign hsb_pad_n = !(ext_low || hsb_pull_low);

  always #5 clk = ~clk;

  nvsram_ctrl #(
    .AW(AW), .DW(DW), .STORE_CYC(ST_CYC), .RECALL_CYC(RC_CYC),
    .SEQ_A0(A0), .SEQ_A1(A1), .SEQ_A2(A2), .SEQ_A3(A3), .SEQ_A4(A4),
    .STORE_TAIL(TS), .RECALL_TAIL(TR)
  ) u_nvsram_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .hsb_pad_n(hsb_pad_n), .hsb_pull_low(hsb_pull_low),
    .pwr_fail(pwr_fail), .pwr_good(pwr_good)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    sram_m[a] = d;
  endtask

  // one read cycle; data checked right after the sampling edge
  task automatic rd(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    @(negedge clk);
    chk(dout_en === 1'b1, req, int'(dout_en), 1);
    chk(dout === sram_m[a], req, int'(dout), int'(sram_m[a]));
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // called at the negedge right after a trigger edge
  task automatic measure(input int exp_len, input bit poke, input string req);
    int len = 0;
    while (hsb_pull_low === 1'b1 && len < 1000) begin
      len++;
      if (poke) begin
        chk(dout_en === 1'b0, "R2 no output while busy", int'(dout_en), 0);
        ce_n = 1'b0; oe_n = 1'b0; addr = 4'd2; din = 8'hEE;
        we_n = len[0];
        ext_low = (len == 5);
      end
      @(negedge clk);
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ext_low = 1'b0;
    chk(len == exp_len, req, len, exp_len);
  endtask

  task automatic seq5();
    rd(A0, "R3 seq read"); rd(A1, "R3 seq read"); rd(A2, "R3 seq read");
    rd(A3, "R3 seq read"); rd(A4, "R3 seq read");
  endtask

  task automatic no_busy(input string req);
    for (int k = 0; k < 3; k++) begin
      chk(hsb_pull_low === 1'b0, req, int'(hsb_pull_low), 0);
      @(negedge clk);
    end
  endtask

  task automatic save_model();
    for (int i = 0; i < N; i++) shad_m[i] = sram_m[i];
  endtask

  task automatic load_model();
    for (int i = 0; i < N; i++) sram_m[i] = shad_m[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout_en === 1'b0, "R1 reset output off", int'(dout_en), 0);
    chk(hsb_pull_low === 1'b0, "R7 reset not busy", int'(hsb_pull_low), 0);

    // R1: exhaustive write/read sweep
    for (int i = 0; i < N; i++) wr(AW'(i), DW'(i * 7 + 3));
    for (int i = 0; i < N; i++) rd(AW'(i), "R1 read back");
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 4'd1;
    @(negedge clk);
    chk(dout_en === 1'b0, "R1 oe_n high keeps bus off", int'(dout_en), 0);
    ce_n = 1'b1;

    // R3 + R7 + R11: software save
    seq5(); rd(TS, "R3 last read");
    save_model();
    measure(ST_LEN, 1'b0, "R7 save length after R3 series");

    // R6 + R2: pad-triggered save with bus pokes and pad pulse during busy
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); ext_low = 1'b0;
    measure(ST_LEN, 1'b1, "R6 pad save length unchanged by pad pulse");
    rd(4'd2, "R2 write during busy ignored");

    // overwrite SRAM, then R4 restore; R10 repeated restore
    for (int i = 0; i < N; i++) wr(AW'(i), DW'((i * 13 + 1) ^ 8'h5A));
    seq5(); rd(TR, "R4 last read");
    load_model();
    measure(RC_LEN, 1'b0, "R7 restore length after R4 series");
    for (int i = 0; i < N; i++) rd(AW'(i), "R10 R11 restored data");
    wr(4'd7, 8'h99);
    seq5(); rd(TR, "R4 last read");
    load_model();
    measure(RC_LEN, 1'b0, "R10 repeat restore length");
    for (int i = 0; i < N; i++) rd(AW'(i), "R10 shadow unchanged");

    // R5: write in the middle aborts
    rd(A0, "R5"); rd(A1, "R5"); rd(A2, "R5");
    wr(4'd9, 8'h42);
    rd(A3, "R5"); rd(A4, "R5"); rd(TS, "R5");
    no_busy("R5 write aborts series");
    // R5: stray read aborts
    rd(A0, "R5"); rd(A1, "R5"); rd(4'd7, "R5"); rd(A2, "R5");
    rd(A3, "R5"); rd(A4, "R5"); rd(TS, "R5");
    no_busy("R5 stray read aborts series");
    // R5: resync on first address
    rd(A0, "R5"); rd(A1, "R5"); rd(A0, "R5"); rd(A1, "R5");
    rd(A2, "R5"); rd(A3, "R5"); rd(A4, "R5"); rd(TS, "R5");
    save_model();
    measure(ST_LEN, 1'b0, "R5 resync series starts save");

    // R8: clean power fail skipped, dirty one saves
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    no_busy("R8 clean power fail ignored");
    pwr_fail = 1'b0;
    wr(4'd4, 8'hC3);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    save_model();
    measure(ST_LEN, 1'b0, "R8 dirty power fail saves");
    pwr_fail = 1'b0;

    // R9: power-good restore
    for (int i = 0; i < N; i++) wr(AW'(i), DW'(255 - i));
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk);
    load_model();
    measure(RC_LEN, 1'b0, "R9 power good restore length");
    for (int i = 0; i < N; i++) rd(AW'(i), "R9 restored data");
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    no_busy("R8 power fail after restore without write ignored");
    pwr_fail = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule